// File: doc/BRIEF.md
# ADC Track and Power-Up Sequencer

This block sits between a convert-start request and a successive-approximation conversion engine. When it accepts a request it decides whether the analog core has to be woken first. It then times a tracking window and finally issues a single-cycle start pulse to the engine. An 8-bit control register selects three things: the burst wake-up delay, where tracking happens relative to the start request, and how long the window after the start lasts. That window is measured in SAR-clock periods plus a fixed number of system-clock cycles.

Three outputs drive the analog side: the core power enable, the track/hold control and the conversion start. A busy flag covers each accepted sequence. Requests that arrive while a sequence runs are dropped. Requests that arrive while the converter is neither enabled nor in burst mode are also dropped.

Top module: `adc_track_seq`

## Requirements
- R1: After reset the control register reads 0xFF on `cfg_q`. A write loads all 8 bits, which the next cycle shows. The fields are: bits 7:4 the wake-up code, bits 3:2 the tracking mode, bits 1:0 the post-window code.
- R2: With `burst_en`=0, `core_pwr` equals `adc_en` in every cycle.
- R3: With `burst_en`=1 and `adc_en`=1, `core_pwr` stays 1 and a sequence has no wake-up wait.
- R4: With `burst_en`=1 and `adc_en`=0, `core_pwr` is 0 while idle. It is 1 from the cycle after an accepted request through the start-pulse cycle, and 0 again afterwards.
- R5: The burst wake-up wait lasts (wake-up code + 1) units of 200 ns, which is 10 cycles each at 50 MHz. During the wait `track` is 0.
- R6: Mode 01 is post-tracking and mode 10 is pre-tracking. Mode 11 is dual tracking, and mode 00 behaves as mode 11. Pre-tracking mode has no window after the request.
- R7: In post and dual modes the window after the request lasts (2 << post-window code) × SAR_DIV cycles plus 2 cycles, with `track`=1 throughout.
- R8: While idle, `track` is 1 exactly when `core_pwr` is 1 and the mode is not post-tracking.
- R9: `sar_start` is a one-cycle pulse in the last cycle of a sequence, with `track`=0 in that cycle.
- R10: `busy` is 1 from the cycle after an accepted request through the `sar_start` cycle. A `conv_req` during a sequence does not change its timing or restart it.
- R11: A `conv_req` while `adc_en`=0 and `burst_en`=0 is ignored: no `busy`, no `sar_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_q | output | 8 | Control register contents |
| adc_en | input | 1 | Converter enable |
| burst_en | input | 1 | Burst (per-conversion wake-up) enable |
| conv_req | input | 1 | Convert-start request |
| core_pwr | output | 1 | Analog core power enable |
| track | output | 1 | 1 = track, 0 = hold |
| busy | output | 1 | Sequence in progress |
| sar_start | output | 1 | One-cycle start to the conversion engine |

## Verification
Sequences are tried in each power context: burst asleep, burst awake and plain enabled. This separates a missing or extra wake-up wait from a mis-sized tracking window. All four mode codes and all post-window codes are exercised. The reserved code is exercised too, which shows whether mode 00 falls back to dual tracking or hangs. Random register values and a stray request injected mid-sequence check that an ignored request neither stretches nor restarts a run. A request with the converter disabled checks the acceptance gate.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC track/power-up sequencer.
// Assumes the 8-bit register layout {wake[3:0], mode[1:0], post[1:0]}.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        TM_RSVD = 2'b00,
        TM_POST = 2'b01,
        TM_PRE  = 2'b10,
        TM_DUAL = 2'b11
    } trk_mode_e;

    typedef struct packed {
        logic [3:0] wake;
        trk_mode_e  mode;
        logic [1:0] post;
    } seq_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_WAKE     = 3'd1,
        S_POST_SAR = 3'd2,
        S_POST_SYS = 3'd3,
        S_START    = 3'd4
    } seq_state_e;

    // Post window is run in every mode except pure pre-tracking (reserved acts as dual).
    function automatic logic has_post(trk_mode_e m);
        return m != TM_PRE;
    endfunction

    // Tracking before the request happens in every mode except pure post-tracking.
    function automatic logic has_pre(trk_mode_e m);
        return m != TM_POST;
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
// Control register of the sequencer: 8 bits, reset to all ones,
// loaded whole on a write strobe. Assumes single-cycle writes.
module adc_seq_cfg
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output seq_cfg_t   cfg,
    output logic [7:0] cfg_q
);

    logic [7:0] cfg_r;

    // Register storage with synchronous reset to 0xFF.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_r <= 8'hFF;
        else if (wr) cfg_r <= wdata;
    end

    assign cfg   = seq_cfg_t'(cfg_r);
    assign cfg_q = cfg_r;

    AST_CFG_RESET_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_q == 8'hFF); // R1
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cfg_q == $past(wdata)); // R1

endmodule

// File: rtl/adc_seq_tick.sv
// Enable-pulse divider. While run is high it pulses tick once every DIV
// cycles, the first pulse DIV cycles after run rises; it restarts whenever
// run drops. Assumes DIV >= 1.
module adc_seq_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Phase counter, cleared while idle so each window starts aligned.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + CW'(1);
    end

    assign tick = run && (cnt == LAST);

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R7

endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencing state machine. It accepts a request when idle and the converter
// is enabled or in burst mode, and snapshots the register at that moment.
// It then runs: optional wake-up wait, optional post window (SAR ticks then
// EXTRA_CYC system cycles), and one start cycle.
// Assumes unit_tick/sar_tick come from dividers gated by wake_run/sar_run.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int EXTRA_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  seq_cfg_t   cfg,
    input  logic       adc_en,
    input  logic       burst_en,
    input  logic       conv_req,
    input  logic       unit_tick,
    input  logic       sar_tick,
    output logic       wake_run,
    output logic       sar_run,
    output logic       core_pwr,
    output logic       track,
    output logic       busy,
    output logic       sar_start
);

    localparam int CMAX  = (EXTRA_CYC > 16) ? EXTRA_CYC : 16;
    localparam int CNT_W = $clog2(CMAX) + 1;
    localparam logic [CNT_W-1:0] SYS_LAST = CNT_W'(EXTRA_CYC - 1);

    seq_state_e       state;
    seq_cfg_t         snap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] post_last;
    logic             accept;
    logic             need_wake;
    seq_state_e       after_post_sar;

    assign accept         = (state == S_IDLE) && conv_req && (adc_en || burst_en);
    assign need_wake      = burst_en && !adc_en;
    assign post_last      = (CNT_W'(2) << snap.post) - CNT_W'(1);
    assign after_post_sar = (EXTRA_CYC > 0) ? S_POST_SYS : S_START;

    // State, step counter and register snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            snap  <= seq_cfg_t'(8'hFF);
        end else begin
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        snap <= cfg;
                        cnt  <= '0;
                        if (need_wake)              state <= S_WAKE;
                        else if (has_post(cfg.mode)) state <= S_POST_SAR;
                        else                        state <= S_START;
                    end
                end
                S_WAKE: begin
                    if (unit_tick) begin
                        if (cnt == CNT_W'(snap.wake)) begin
                            cnt   <= '0;
                            state <= has_post(snap.mode) ? S_POST_SAR : S_START;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                S_POST_SAR: begin
                    if (sar_tick) begin
                        if (cnt == post_last) begin
                            cnt   <= '0;
                            state <= after_post_sar;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                S_POST_SYS: begin
                    if (cnt == SYS_LAST) begin
                        cnt   <= '0;
                        state <= S_START;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                S_START: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output decode from state and live enables.
    always_comb begin
        wake_run  = (state == S_WAKE);
        sar_run   = (state == S_POST_SAR);
        busy      = (state != S_IDLE);
        sar_start = (state == S_START);
        core_pwr  = burst_en ? (adc_en || busy) : adc_en;
        track     = (state == S_POST_SAR) || (state == S_POST_SYS) ||
                    ((state == S_IDLE) && has_pre(cfg.mode) && core_pwr);
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sar_start |=> !sar_start); // R9
    AST_HOLD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        sar_start |-> !track); // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R10
    AST_RUN_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sar_start) |=> busy); // R10
    AST_DISABLED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !adc_en && !burst_en) |=> !busy); // R11
    AST_WAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAKE) |-> cnt <= CNT_W'(snap.wake)); // R5

endmodule

// File: rtl/adc_track_seq.sv
// Top of the ADC track/power-up sequencer. It derives the wake-up unit
// (UNIT_NS) from CLK_HZ and the SAR tick from SAR_DIV, and wires the
// register, the two dividers and the state machine.
// Assumes CLK_HZ is a multiple of 1 MHz.
module adc_track_seq
    import adc_seq_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int UNIT_NS   = 200,
    parameter int SAR_DIV   = 4,
    parameter int EXTRA_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_q,
    input  logic       adc_en,
    input  logic       burst_en,
    input  logic       conv_req,
    output logic       core_pwr,
    output logic       track,
    output logic       busy,
    output logic       sar_start
);

    localparam int UNIT_RAW = (CLK_HZ / 1_000_000) * UNIT_NS / 1000;
    localparam int UNIT_DIV = (UNIT_RAW < 1) ? 1 : UNIT_RAW;

    seq_cfg_t cfg;
    logic     wake_run;
    logic     sar_run;
    logic     unit_tick;
    logic     sar_tick;

    adc_seq_cfg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .cfg_q (cfg_q)
    );

    adc_seq_tick #(.DIV(UNIT_DIV)) i_unit_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wake_run),
        .tick  (unit_tick)
    );

    adc_seq_tick #(.DIV(SAR_DIV)) i_sar_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sar_run),
        .tick  (sar_tick)
    );

    adc_seq_fsm #(.EXTRA_CYC(EXTRA_CYC)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .adc_en    (adc_en),
        .burst_en  (burst_en),
        .conv_req  (conv_req),
        .unit_tick (unit_tick),
        .sar_tick  (sar_tick),
        .wake_run  (wake_run),
        .sar_run   (sar_run),
        .core_pwr  (core_pwr),
        .track     (track),
        .busy      (busy),
        .sar_start (sar_start)
    );

endmodule

// File: tb/test_adc_track_seq.sv
module test_adc_track_seq;

    localparam int UNIT = 10;
    localparam int SDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_q;
    logic       adc_en = 1'b0;
    logic       burst_en = 1'b0;
    logic       conv_req = 1'b0;
    logic       core_pwr, track, busy, sar_start;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    adc_track_seq #(.CLK_HZ(50_000_000), .UNIT_NS(200), .SAR_DIV(SDIV), .EXTRA_CYC(2))
    i_adc_track_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .adc_en(adc_en), .burst_en(burst_en), .conv_req(conv_req),
        .core_pwr(core_pwr), .track(track), .busy(busy), .sar_start(sar_start)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int wake_len(logic b, logic a, logic [7:0] c);
        return (b && !a) ? (int'(c[7:4]) + 1) * UNIT : 0;
    endfunction

    function automatic int post_len(logic [7:0] c);
        return (c[3:2] == 2'b10) ? 0 : ((2 << c[1:0]) * SDIV + 2);
    endfunction

    // Write the register, start one sequence, check it cycle by cycle.
    task automatic run_seq(input logic b, input logic a, input logic [7:0] c, input int inj);
        int w, p, len;
        w = wake_len(b, a, c);
        p = post_len(c);
        len = w + p + 1;
        @(negedge clk);
        burst_en = b; adc_en = a; cfg_wr = 1'b1; cfg_wdata = c;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(cfg_q == c, "R1 cfg load", cfg_q, c);
        chk(core_pwr == a, "R2/R3/R4 idle power", core_pwr, a);
        chk(track == (a && c[3:2] != 2'b01), "R8 idle track", track, a && c[3:2] != 2'b01);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        for (int i = 1; i <= len; i++) begin
            if (i > 1) @(negedge clk);
            conv_req = (i == inj);
            chk(busy == 1'b1, "R10 busy", busy, 1);
            chk(sar_start == (i == len), "R9 start timing", sar_start, i == len);
            chk(core_pwr == 1'b1, "R3/R4 power in run", core_pwr, 1);
            if (i <= w)
                chk(track == 1'b0, "R5 wake track", track, 0);
            else if (i < len)
                chk(track == 1'b1, "R7/R6 post window", track, 1);
            else
                chk(track == 1'b0, "R9 hold at start", track, 0);
        end
        @(negedge clk);
        conv_req = 1'b0;
        chk(busy == 1'b0, "R10 busy end", busy, 0);
        chk(sar_start == 1'b0, "R9 start single", sar_start, 0);
        chk(core_pwr == a, "R4 power after", core_pwr, a);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_q == 8'hFF, "R1 reset value", cfg_q, 8'hFF);
        chk(busy == 1'b0, "R10 reset idle", busy, 0);
        chk(sar_start == 1'b0, "R9 reset idle", sar_start, 0);

        // R2: power follows enable with burst off
        burst_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            adc_en = k[0];
            @(negedge clk);
            chk(core_pwr == adc_en, "R2 follow enable", core_pwr, adc_en);
        end

        // R11: request ignored when disabled
        adc_en = 1'b0; burst_en = 1'b0;
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk(busy == 1'b0 && sar_start == 1'b0, "R11 disabled ignore", busy, 0);
            @(negedge clk);
        end

        // Directed corner cases
        run_seq(1'b1, 1'b0, 8'hFF, 0);   // R4 R5 longest wake, dual, longest window
        run_seq(1'b1, 1'b0, 8'h00, 5);   // R5 shortest wake, reserved mode as dual (R6)
        run_seq(1'b0, 1'b1, 8'h08, 0);   // R6 pre-tracking: immediate start
        run_seq(1'b1, 1'b1, 8'h35, 3);   // R3 no wait, post mode, code 01
        run_seq(1'b0, 1'b1, 8'h06, 4);   // R7 post mode, code 10
        run_seq(1'b1, 1'b0, 8'h78, 7);   // R5 wake then pre: start after wake

        // Constrained random sequences
        for (int n = 0; n < 30; n++) begin
            logic       b, a;
            logic [7:0] c;
            int         len, inj;
            b = 1'($urandom % 2);
            a = b ? 1'($urandom % 2) : 1'b1;
            c = 8'($urandom);
            len = wake_len(b, a, c) + post_len(c) + 1;
            inj = (len >= 3) ? 2 + int'($urandom % (len - 2)) : 0;
            run_seq(b, a, c, inj);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule